// File: doc/BRIEF.md
# Demand Pacing Controller

This block decides when to fire a pacing pulse into a heart chamber. After each beat, whether that beat was sensed or paced, it restarts a countdown timer. It then waits. If a natural beat is sensed before the timer runs out, no pulse is issued and the timer simply starts again. If the timer runs out first, the block fires a one-cycle pace pulse and then restarts the timer. The timeout is a parameter counted in clock cycles. The default is 40,000,000 cycles, which is 0.8 s at 50 MHz. A test setup can use a much shorter value.

The block has two variants, picked by a parameter:

- **Single-chamber:** only the atrial pins are used, and one timer runs the waiting phase over and over.
- **Dual-chamber:** the block alternates between an atrial phase and a ventricular phase. Each phase has its own timer, sense input and pace output. The end of the atrial phase, by a sensed beat or by a pace, starts the ventricular phase. The end of the ventricular phase starts the next atrial phase.

The top module contains both timers. It brings out their expiry flags and restart strobes, so the sequence can be watched at the pins.

Top module: `pace_ctl_top`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, the controller is in the atrial timer-restart state. In that state `restart_a_o` = 1 and both pace outputs are 0.
- R2: A restart strobe reloads its timer on the next edge, and the timer then counts down. The chamber's expiry flag is 0 in the cycle after a strobe. It goes to 1 exactly TIMEOUT_CYCLES+1 cycles after the strobe cycle, and stays 1 until the next strobe.
- R3: A restart state lasts exactly one cycle and is always followed by the wait state of the same chamber, whatever the sense inputs do. In the wait state both the restart strobe and the pace output are 0.
- R4: If no beat is sensed during the wait, the pace output for that chamber is 1 in exactly one cycle. That cycle comes TIMEOUT_CYCLES+2 cycles after the restart strobe cycle.
- R5: A beat sensed in the wait state prevents the pace. It ends the wait on the next edge. In single-chamber mode the next state is the atrial restart. In dual-chamber mode an atrial beat leads to the ventricular restart (`restart_v_o` = 1), and a ventricular beat leads to the atrial restart.
- R6: If a beat is sensed in the same cycle that the expiry flag is 1, the sensed beat wins. No pace is issued, and the controller moves on as in R5.
- R7: A sense input that is high during a restart state or a pace state has no effect on the next state.
- R8: In dual-chamber mode, an atrial pace is followed on the next cycle by the ventricular restart, and a ventricular pace by the atrial restart. The atrial pace therefore always comes before the ventricular pace in a sequence.
- R9: Beats sensed at intervals shorter than the timeout never cause a pace in either chamber.
- R10: In single-chamber mode, `pace_v_o`, `restart_v_o` and `expired_v_o` stay 0 and `beat_v_i` is ignored. An atrial pace is followed by the atrial restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| beat_a_i | input | 1 | Atrial (or single-chamber) sensed beat, one sample per cycle |
| beat_v_i | input | 1 | Ventricular sensed beat (dual-chamber only) |
| restart_a_o | output | 1 | Atrial timer restart strobe, high in the atrial restart state |
| restart_v_o | output | 1 | Ventricular timer restart strobe |
| pace_a_o | output | 1 | Atrial pace pulse, one cycle per pace |
| pace_v_o | output | 1 | Ventricular pace pulse, one cycle per pace |
| expired_a_o | output | 1 | Atrial timer has reached zero |
| expired_v_o | output | 1 | Ventricular timer has reached zero |

## Verification
The bench measures the exact cycle of expiry and of the pace. A design with an off-by-one reload or decrement would shift both by a cycle. A tie between a sensed beat and expiry is forced on purpose: a design that let the timeout win would fire a pace even though the heart had beaten. Beats are also placed in the restart and pace states, where a design that decoded them there would skip or repeat a phase. A run of regular beats, the check that the atrial pace comes before the ventricular one, and checks that the single-chamber variant keeps its ventricular pins quiet complete the set.

// File: rtl/pace_ctl_pkg.sv
`timescale 1ns/1ps
package pace_ctl_pkg;

    // Dual-chamber phases; order is the pacing sequence
    typedef enum logic [2:0] {
        PH_RST_A  = 3'd0,
        PH_WAIT_A = 3'd1,
        PH_PACE_A = 3'd2,
        PH_RST_V  = 3'd3,
        PH_WAIT_V = 3'd4,
        PH_PACE_V = 3'd5
    } dual_phase_e;

    // Single-chamber phases
    typedef enum logic [1:0] {
        SC_RST  = 2'd0,
        SC_WAIT = 2'd1,
        SC_PACE = 2'd2
    } single_phase_e;

    // Per-chamber outputs of a controller
    typedef struct packed {
        logic restart;
        logic pace;
    } chamber_ctl_s;

    // Wait-state decision: a sensed beat beats the timeout
    typedef enum logic [1:0] {
        WD_STAY  = 2'd0,
        WD_SENSE = 2'd1,
        WD_PACE  = 2'd2
    } wait_dec_e;

    function automatic wait_dec_e wait_decide(input logic beat, input logic expired);
        if (beat)
            return WD_SENSE;
        else if (expired)
            return WD_PACE;
        else
            return WD_STAY;
    endfunction

endpackage

// File: rtl/pace_timeout_timer.sv
`timescale 1ns/1ps
module pace_timeout_timer #(
    parameter int unsigned TIMEOUT_CYCLES = 40000000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart_i,
    output logic expired_o
);
    localparam int unsigned CNT_W = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(TIMEOUT_CYCLES);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst)
            count_q <= LOAD_VAL;
        else if (restart_i)
            count_q <= LOAD_VAL;
        else if (count_q != '0)
            count_q <= count_q - 1'b1;
    end

    assign expired_o = (count_q == '0);
endmodule

// File: rtl/pace_ctl_single.sv
`timescale 1ns/1ps
module pace_ctl_single
    import pace_ctl_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         beat_i,
    input  logic         expired_i,
    output chamber_ctl_s ctl_o
);
    single_phase_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SC_RST:  state_d = SC_WAIT;
            SC_WAIT: begin
                unique case (wait_decide(beat_i, expired_i))
                    WD_SENSE: state_d = SC_RST;
                    WD_PACE:  state_d = SC_PACE;
                    default:  state_d = SC_WAIT;
                endcase
            end
            SC_PACE: state_d = SC_RST;
            default: state_d = SC_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= SC_RST;
        else
            state_q <= state_d;
    end

    assign ctl_o.restart = (state_q == SC_RST);
    assign ctl_o.pace    = (state_q == SC_PACE);
endmodule

// File: rtl/pace_ctl_dual.sv
`timescale 1ns/1ps
module pace_ctl_dual
    import pace_ctl_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         beat_a_i,
    input  logic         beat_v_i,
    input  logic         expired_a_i,
    input  logic         expired_v_i,
    output chamber_ctl_s ctl_a_o,
    output chamber_ctl_s ctl_v_o
);
    dual_phase_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_RST_A:  state_d = PH_WAIT_A;
            PH_WAIT_A: begin
                unique case (wait_decide(beat_a_i, expired_a_i))
                    WD_SENSE: state_d = PH_RST_V;
                    WD_PACE:  state_d = PH_PACE_A;
                    default:  state_d = PH_WAIT_A;
                endcase
            end
            PH_PACE_A: state_d = PH_RST_V;
            PH_RST_V:  state_d = PH_WAIT_V;
            PH_WAIT_V: begin
                unique case (wait_decide(beat_v_i, expired_v_i))
                    WD_SENSE: state_d = PH_RST_A;
                    WD_PACE:  state_d = PH_PACE_V;
                    default:  state_d = PH_WAIT_V;
                endcase
            end
            PH_PACE_V: state_d = PH_RST_A;
            default:   state_d = PH_RST_A;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= PH_RST_A;
        else
            state_q <= state_d;
    end

    assign ctl_a_o.restart = (state_q == PH_RST_A);
    assign ctl_a_o.pace    = (state_q == PH_PACE_A);
    assign ctl_v_o.restart = (state_q == PH_RST_V);
    assign ctl_v_o.pace    = (state_q == PH_PACE_V);
endmodule

// File: rtl/pace_ctl_top.sv
`timescale 1ns/1ps
module pace_ctl_top
    import pace_ctl_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYCLES = 40000000,
    parameter bit          DUAL_CHAMBER   = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic beat_a_i,
    input  logic beat_v_i,
    output logic restart_a_o,
    output logic restart_v_o,
    output logic pace_a_o,
    output logic pace_v_o,
    output logic expired_a_o,
    output logic expired_v_o
);
    chamber_ctl_s ctl_a, ctl_v;
    logic         exp_a, exp_v;

    pace_timeout_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer_a (
        .clk       (clk),
        .rst       (rst),
        .restart_i (ctl_a.restart),
        .expired_o (exp_a)
    );

    generate
        if (DUAL_CHAMBER) begin : g_dual
            pace_timeout_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer_v (
                .clk       (clk),
                .rst       (rst),
                .restart_i (ctl_v.restart),
                .expired_o (exp_v)
            );

            pace_ctl_dual u_ctl (
                .clk         (clk),
                .rst         (rst),
                .beat_a_i    (beat_a_i),
                .beat_v_i    (beat_v_i),
                .expired_a_i (exp_a),
                .expired_v_i (exp_v),
                .ctl_a_o     (ctl_a),
                .ctl_v_o     (ctl_v)
            );
        end else begin : g_single
            logic unused_beat_v;
            assign unused_beat_v = beat_v_i;
            assign exp_v = 1'b0;
            assign ctl_v = '0;

            pace_ctl_single u_ctl (
                .clk       (clk),
                .rst       (rst),
                .beat_i    (beat_a_i),
                .expired_i (exp_a),
                .ctl_o     (ctl_a)
            );
        end
    endgenerate

    assign restart_a_o = ctl_a.restart;
    assign pace_a_o    = ctl_a.pace;
    assign restart_v_o = ctl_v.restart;
    assign pace_v_o    = ctl_v.pace;
    assign expired_a_o = exp_a;
    assign expired_v_o = exp_v;
endmodule

// File: rtl/pace_ctl_checker.sv
`timescale 1ns/1ps
module pace_ctl_checker #(
    parameter bit DUAL_CHAMBER = 1'b1
) (
    input logic clk,
    input logic rst,
    input logic beat_a_i,
    input logic beat_v_i,
    input logic restart_a_o,
    input logic restart_v_o,
    input logic pace_a_o,
    input logic pace_v_o,
    input logic expired_a_o,
    input logic expired_v_o
);
    // R1: first cycle after reset is the atrial restart
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (restart_a_o && !pace_a_o && !pace_v_o));

    // R2: a strobe reloads the timer, so no expiry in the next cycle
    a_r2_reload_a: assert property (@(posedge clk) disable iff (rst)
        restart_a_o |=> !expired_a_o);

    // R3: restart lasts one cycle and leads to wait
    a_r3_restart_to_wait: assert property (@(posedge clk) disable iff (rst)
        restart_a_o |=> (!restart_a_o && !pace_a_o));

    // R4: pace pulses are single cycle
    a_r4_pace_one_cycle: assert property (@(posedge clk) disable iff (rst)
        pace_a_o |=> !pace_a_o);

    // R6: a pace needs an expiry with no sensed beat one cycle earlier
    a_r6_sense_wins_a: assert property (@(posedge clk) disable iff (rst)
        pace_a_o |-> ($past(expired_a_o) && !$past(beat_a_i)));

    a_r4_at_most_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({restart_a_o, restart_v_o, pace_a_o, pace_v_o}));

    generate
        if (DUAL_CHAMBER) begin : g_dual_chk
            a_r2_reload_v: assert property (@(posedge clk) disable iff (rst)
                restart_v_o |=> !expired_v_o);
            a_r6_sense_wins_v: assert property (@(posedge clk) disable iff (rst)
                pace_v_o |-> ($past(expired_v_o) && !$past(beat_v_i)));
            a_r8_pace_a_to_restart_v: assert property (@(posedge clk) disable iff (rst)
                pace_a_o |=> restart_v_o);
            a_r8_pace_v_to_restart_a: assert property (@(posedge clk) disable iff (rst)
                pace_v_o |=> restart_a_o);
        end else begin : g_single_chk
            a_r10_pace_to_restart: assert property (@(posedge clk) disable iff (rst)
                pace_a_o |=> restart_a_o);
            a_r10_v_quiet: assert property (@(posedge clk) disable iff (rst)
                !pace_v_o && !restart_v_o && !expired_v_o);
        end
    endgenerate
endmodule

bind pace_ctl_top pace_ctl_checker #(.DUAL_CHAMBER(DUAL_CHAMBER)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .beat_a_i    (beat_a_i),
    .beat_v_i    (beat_v_i),
    .restart_a_o (restart_a_o),
    .restart_v_o (restart_v_o),
    .pace_a_o    (pace_a_o),
    .pace_v_o    (pace_v_o),
    .expired_a_o (expired_a_o),
    .expired_v_o (expired_v_o)
);

// File: tb/pace_ctl_top_tb.sv
`timescale 1ns/1ps
module pace_ctl_top_tb;
    localparam int T = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ba = 1'b0, bv = 1'b0;
    logic sba = 1'b0, sbv = 1'b0;
    logic ra, rv, pa, pv, ea, ev;
    logic sra, srv, spa, spv, sea, sev;

    int n_run = 0;
    int n_fail = 0;
    int sc_v_activity = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pace_ctl_top #(.TIMEOUT_CYCLES(T), .DUAL_CHAMBER(1'b1)) u_dut (
        .clk(clk), .rst(rst), .beat_a_i(ba), .beat_v_i(bv),
        .restart_a_o(ra), .restart_v_o(rv), .pace_a_o(pa), .pace_v_o(pv),
        .expired_a_o(ea), .expired_v_o(ev)
    );

    pace_ctl_top #(.TIMEOUT_CYCLES(T), .DUAL_CHAMBER(1'b0)) u_dut_sc (
        .clk(clk), .rst(rst), .beat_a_i(sba), .beat_v_i(sbv),
        .restart_a_o(sra), .restart_v_o(srv), .pace_a_o(spa), .pace_v_o(spv),
        .expired_a_o(sea), .expired_v_o(sev)
    );

    always @(negedge clk)
        if (!rst && (spv || srv || sev)) sc_v_activity++;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic sync_ra();
        for (int i = 0; i < 100; i++) begin
            if (ra) return;
            tick();
        end
    endtask

    task automatic sync_sra();
        for (int i = 0; i < 100; i++) begin
            if (sra) return;
            tick();
        end
    endtask

    // R1 reset state
    task automatic t_reset();
        check(ra && !pa && !pv && !rv, "R1 reset state restart_a", int'(ra), 1);
    endtask

    // R2 R3 R4 R8: full dual sequence with no beats
    task automatic t_dual_timeout();
        int k_exp, k_pace;
        sync_ra();
        k_exp = -1; k_pace = -1;
        for (int k = 1; k <= T + 2; k++) begin
            tick();
            if (k == 1) check(!ra && !pa, "R3 restart then wait", int'(ra), 0);
            if (ea && k_exp < 0) k_exp = k;
            if (pa && k_pace < 0) k_pace = k;
        end
        check(k_exp == T + 1, "R2 atrial expiry cycle", k_exp, T + 1);
        check(k_pace == T + 2, "R4 atrial pace cycle", k_pace, T + 2);
        tick();
        check(!pa && rv, "R8 pace_a then restart_v", int'(rv), 1);
        k_pace = -1;
        for (int k = 1; k <= T + 2; k++) begin
            tick();
            if (pa) check(0, "R8 atrial pace inside ventricular phase", 1, 0);
            if (pv && k_pace < 0) k_pace = k;
        end
        check(k_pace == T + 2, "R4 ventricular pace cycle", k_pace, T + 2);
        tick();
        check(!pv && ra, "R8 pace_v then restart_a", int'(ra), 1);
    endtask

    // R6: beat coincides with expiry
    task automatic t_tie();
        sync_ra();
        repeat (T + 1) tick();
        check(ea == 1'b1, "R6 expiry visible before tie", int'(ea), 1);
        ba = 1'b1;
        tick();
        ba = 1'b0;
        check(!pa && rv, "R6 sense wins over timeout", int'(pa), 0);
    endtask

    // R5: late atrial beat, then ventricular beat
    task automatic t_sense_chain();
        sync_ra();
        repeat (T) tick();
        ba = 1'b1;
        tick();
        ba = 1'b0;
        check(rv && !pa, "R5 atrial beat to restart_v", int'(rv), 1);
        repeat (3) tick();
        bv = 1'b1;
        tick();
        bv = 1'b0;
        check(ra && !pv, "R5 ventricular beat to restart_a", int'(ra), 1);
    endtask

    // R7: beats in restart and pace states are ignored
    task automatic t_ignored();
        int k_pace;
        sync_ra();
        ba = 1'b1; bv = 1'b1;
        tick();
        ba = 1'b0; bv = 1'b0;
        check(!ra && !rv && !pa, "R7 beat in restart ignored", int'(rv), 0);
        k_pace = -1;
        for (int k = 2; k <= T + 2; k++) begin
            tick();
            if (pa && k_pace < 0) k_pace = k;
        end
        check(k_pace == T + 2, "R7 pace timing after ignored beat", k_pace, T + 2);
        ba = 1'b1; bv = 1'b1;
        tick();
        ba = 1'b0; bv = 1'b0;
        check(rv && !ra && !pa, "R7 beat in pace ignored", int'(rv), 1);
        tick();
        check(!rv && !ra && !pv, "R7 ventricular wait after pace", int'(rv), 0);
    endtask

    // R9: regular beats never pace
    task automatic t_regular();
        int paces = 0, nra = 0, nrv = 0;
        for (int i = 0; i < 200; i++) begin
            ba = (i % 4 == 0);
            bv = (i % 4 == 0);
            tick();
            if (pa || pv) paces++;
            if (ra) nra++;
            if (rv) nrv++;
        end
        ba = 1'b0; bv = 1'b0;
        check(paces == 0, "R9 no pacing under regular beats", paces, 0);
        check(nra > 0 && nrv > 0, "R9 both phases restarted", nra + nrv, 1);
    endtask

    // R10: single-chamber period, beat, tie
    task automatic t_single();
        int k_pace;
        sync_sra();
        k_pace = -1;
        for (int k = 1; k <= T + 2; k++) begin
            tick();
            if (spa && k_pace < 0) k_pace = k;
        end
        check(k_pace == T + 2, "R10 single pace cycle", k_pace, T + 2);
        tick();
        check(sra && !spa, "R10 single pace then restart", int'(sra), 1);
        repeat (3) tick();
        sba = 1'b1; sbv = 1'b1;
        tick();
        sba = 1'b0; sbv = 1'b0;
        check(sra && !spa, "R5 single beat restarts", int'(sra), 1);
        repeat (T + 1) tick();
        sba = 1'b1;
        tick();
        sba = 1'b0;
        check(sra && !spa, "R6 single tie sense wins", int'(spa), 0);
        check(sc_v_activity == 0, "R10 ventricular pins quiet", sc_v_activity, 0);
    endtask

    initial begin
        repeat (3) tick();
        t_reset();
        rst = 1'b0;
        t_reset();
        t_dual_timeout();
        t_tie();
        t_sense_chain();
        t_ignored();
        t_regular();
        t_single();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule